// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes the four shared PCI interrupt lines (A to D, active low on the pins) and two plug-and-play interrupt requests (active high), and steers each of them onto one of sixteen ISA-style IRQ outputs. Every source has its own 4-bit target number, taken from three routing bytes. Targets 0, 2 and 13 are reserved. A source aimed at a reserved target drives nothing, and an illegal-route flag for that source is raised. When several sources aim at the same IRQ, their requests are OR-combined.

Each PCI line also has a mode bit. When the bit is clear, the line is taken as non-inverted and level-sensitive: a low pin asserts its IRQ for as long as it stays low. When the bit is set, the line is inverted and edge-triggered: a rising edge on the pin sets a sticky pending bit. That bit keeps the IRQ asserted until the line's clear input is pulsed. All raw pins first pass through a two-flop synchroniser. The IRQ vector and the flags are registered, so software can change the configuration bytes at any time. Interrupt prioritisation and the interrupt controller are not part of this block.

Top module: `irq_steer_router`

## Requirements
- R1: While reset is low, and on the first edge after it, irq_out and bad_route are all zero, and no pending bit is held.
- R2: The routing fields are laid out as follows: line A is route_ab[7:4], line B is route_ab[3:0], line C is route_cp[7:4], plug-and-play request 1 is route_cp[3:0], line D is route_dp[7:4], and plug-and-play request 0 is route_dp[3:0]. Each field is the number of the IRQ it drives.
- R3: A PCI line whose mode bit is 0 drives its target IRQ high exactly while its pin is low. A pin change shows at irq_out on the third rising clock edge after it is applied (two synchroniser flops and one output register).
- R4: pol_cfg bit 3 sets the mode of line A, bit 2 line B, bit 1 line C and bit 0 line D. Bits 7 to 4 have no effect on any output.
- R5: A PCI line whose mode bit is 1 sets a pending bit on a rising edge of its pin. The bit drives the target IRQ from the fourth edge after the pin change, and it stays asserted when the pin falls again.
- R6: A one-cycle pulse on edge_clr[i] (i = 0..3 for lines A..D) drops the pending bit of that line, and the IRQ falls on the second edge after the pulse is applied. If a new rising edge arrives in the same cycle as the clear, the set wins. A clear sent to a level-mode line has no effect, and a line in level mode holds no pending bit.
- R7: A source whose field is 0, 2 or 13 drives no IRQ, and IRQ outputs 0, 2 and 13 are never asserted. bad_route bit k is 1 while the field of source k is reserved, one cycle after the field is set. The source order is A, B, C, D, plug-and-play 0, plug-and-play 1 for k = 0 to 5.
- R8: When sources share a target, the IRQ is the OR of their requests.
- R9: The plug-and-play requests are active-high and level-sensitive, with the same three-edge latency as R3.
- R10: An edge-mode line whose pin stays high after a clear does not set its pending bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pci_int_n | input | 4 | Raw PCI interrupt pins, bit 0 = line A to bit 3 = line D |
| pnp_req | input | 2 | Raw plug-and-play requests, active high |
| route_ab | input | 8 | Targets for lines A (high nibble) and B (low nibble) |
| route_cp | input | 8 | Targets for line C (high nibble) and plug-and-play 1 (low nibble) |
| route_dp | input | 8 | Targets for line D (high nibble) and plug-and-play 0 (low nibble) |
| pol_cfg | input | 8 | Per-line mode bits: bit 3 = A, bit 0 = D; 0 = level, 1 = inverted edge |
| edge_clr | input | 4 | Per-line pending clear pulse, bit 0 = line A |
| irq_out | output | 16 | Steered IRQ vector |
| bad_route | output | 6 | Per-source reserved-target flags |

## Verification
The main sweep steers each of the six sources to every one of the sixteen targets in turn, with all other sources parked on a reserved value. This shows that every field reaches the right output line and nowhere else, and that each reserved value is both silenced and flagged. Shared-target and all-distinct patterns separate OR-merging from an accidental priority selection. Per-line edge sequences separate the sticky, set-wins-over-clear and held-high behaviour from plain level following. Latency probes sample one edge before and one edge at the expected change, which catches a missing or extra synchroniser stage.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int IRQ_NUM_W = 4;
    localparam int NUM_IRQ   = 1 << IRQ_NUM_W;
    localparam int NUM_PCI   = 4;
    localparam int NUM_PNP   = 2;
    localparam int NUM_SRC   = NUM_PCI + NUM_PNP;

    typedef logic [IRQ_NUM_W-1:0] irq_num_t;

    // Targets that must never be driven by any source.
    function automatic logic irq_is_reserved(irq_num_t n);
        return (n == irq_num_t'(0)) || (n == irq_num_t'(2)) || (n == irq_num_t'(13));
    endfunction

    // The mode byte lists line A in its highest used bit; reorder so that
    // index 0 is line A. The upper nibble is reserved and ignored.
    function automatic logic [NUM_PCI-1:0] pol_to_edge(logic [7:0] pol);
        logic [NUM_PCI-1:0] r;
        for (int i = 0; i < NUM_PCI; i++) begin
            r[i] = pol[NUM_PCI-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stage[STAGES-1];

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,        // synchronised pin levels
    input  logic [N-1:0] edge_mode,  // 1 = inverted, edge-triggered
    input  logic [N-1:0] clr,        // per-line pending clear
    output logic [N-1:0] req,
    output logic [N-1:0] pend
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } cond_st_t;

    cond_st_t     st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        st_d      = st_q;
        rise      = lvl & ~st_q.prev;
        st_d.prev = lvl;
        // A new edge takes priority over a clear in the same cycle;
        // level-mode lines never keep a pending bit.
        st_d.pend = edge_mode & ((st_q.pend & ~clr) | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_req
            assign req[g] = edge_mode[g] ? st_q.pend[g] : ~lvl[g];
        end
    endgenerate

    assign pend = st_q.pend;

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
    import irq_steer_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_req,
    input  irq_num_t [NSRC-1:0]  src_route,
    output logic [NUM_IRQ-1:0]   irq_vec,
    output logic [NSRC-1:0]      bad_vec
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] irq;
        logic [NSRC-1:0]    bad;
    } merge_st_t;

    merge_st_t                      st_d, st_q;
    logic [NSRC-1:0]                legal;
    logic [NSRC-1:0][NUM_IRQ-1:0]   hit;

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_dec
            assign legal[s] = ~irq_is_reserved(src_route[s]);
            assign hit[s]   = (src_req[s] && legal[s])
                              ? (NUM_IRQ'(1) << src_route[s]) : '0;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        for (int i = 0; i < NSRC; i++) begin
            st_d.irq = st_d.irq | hit[i];
        end
        st_d.bad = ~legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_vec = st_q.irq;
    assign bad_vec = st_q.bad;

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PCI-1:0]  pci_int_n,
    input  logic [NUM_PNP-1:0]  pnp_req,
    input  logic [7:0]          route_ab,
    input  logic [7:0]          route_cp,
    input  logic [7:0]          route_dp,
    input  logic [7:0]          pol_cfg,
    input  logic [NUM_PCI-1:0]  edge_clr,
    output logic [NUM_IRQ-1:0]  irq_out,
    output logic [NUM_SRC-1:0]  bad_route
);

    logic [NUM_PCI-1:0]       pci_lvl;
    logic [NUM_PNP-1:0]       pnp_lvl;
    logic [NUM_PCI-1:0]       line_edge;
    logic [NUM_PCI-1:0]       line_pend;
    logic [NUM_PCI-1:0]       pci_req;
    logic [NUM_SRC-1:0]       src_req;
    irq_num_t [NUM_SRC-1:0]   src_route;

    irq_sync #(
        .WIDTH   (NUM_PCI),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NUM_PCI{1'b1}})
    ) u_sync_pci (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pci_int_n),
        .dout (pci_lvl)
    );

    irq_sync #(
        .WIDTH   (NUM_PNP),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NUM_PNP{1'b0}})
    ) u_sync_pnp (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pnp_req),
        .dout (pnp_lvl)
    );

    assign line_edge = pol_to_edge(pol_cfg);

    irq_line_cond #(
        .N(NUM_PCI)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pci_lvl),
        .edge_mode(line_edge),
        .clr      (edge_clr),
        .req      (pci_req),
        .pend     (line_pend)
    );

    // Source order: A, B, C, D, plug-and-play 0, plug-and-play 1.
    assign src_req      = {pnp_lvl[1], pnp_lvl[0], pci_req};
    assign src_route[0] = route_ab[7:4];
    assign src_route[1] = route_ab[3:0];
    assign src_route[2] = route_cp[7:4];
    assign src_route[3] = route_dp[7:4];
    assign src_route[4] = route_dp[3:0];
    assign src_route[5] = route_cp[3:0];

    irq_route_merge #(
        .NSRC(NUM_SRC)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .src_route(src_route),
        .irq_vec  (irq_out),
        .bad_vec  (bad_route)
    );

endmodule

module irq_steer_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] route_ab,
    input logic [7:0] route_cp,
    input logic [7:0] route_dp,
    input logic [3:0] line_edge,
    input logic [3:0] line_pend,
    input logic [3:0] edge_clr,
    input logic [15:0] irq_out,
    input logic [5:0] bad_route
);

    function automatic logic rsv(logic [3:0] n);
        return (n == 4'd0) || (n == 4'd2) || (n == 4'd13);
    endfunction

    logic [5:0] rsv_now;
    assign rsv_now = {rsv(route_cp[3:0]), rsv(route_dp[3:0]), rsv(route_dp[7:4]),
                      rsv(route_cp[7:4]), rsv(route_ab[3:0]), rsv(route_ab[7:4])};

    // R1: reset leaves outputs cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && bad_route == '0));

    // R7: reserved outputs stay quiet
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out[0] && !irq_out[2] && !irq_out[13]));

    // R7: flags follow the routing fields one cycle later
    a_r7_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bad_route == $past(rsv_now)));

    // R5: a pending bit survives while its line stays in edge mode and no clear arrives
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(line_pend & ~edge_clr & line_edge) & ~line_pend) == 4'h0));

    // R6: no pending bit after a cycle in level mode
    a_r6_level_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((line_pend & ~$past(line_edge)) == 4'h0));

endmodule

bind irq_steer_router irq_steer_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .route_ab (route_ab),
    .route_cp (route_cp),
    .route_dp (route_dp),
    .line_edge(line_edge),
    .line_pend(line_pend),
    .edge_clr (edge_clr),
    .irq_out  (irq_out),
    .bad_route(bad_route)
);

// File: tb/tb_irq_steer_router.sv
module tb_irq_steer_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pci_int_n = 4'hF;
    logic [1:0]  pnp_req = 2'b00;
    logic [7:0]  route_ab = 8'h00;
    logic [7:0]  route_cp = 8'h00;
    logic [7:0]  route_dp = 8'h00;
    logic [7:0]  pol_cfg = 8'h00;
    logic [3:0]  edge_clr = 4'h0;
    logic [15:0] irq_out;
    logic [5:0]  bad_route;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] rt [6];

    always #5 clk = ~clk;

    irq_steer_router dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pci_int_n(pci_int_n),
        .pnp_req  (pnp_req),
        .route_ab (route_ab),
        .route_cp (route_cp),
        .route_dp (route_dp),
        .pol_cfg  (pol_cfg),
        .edge_clr (edge_clr),
        .irq_out  (irq_out),
        .bad_route(bad_route)
    );

    function automatic bit is_rsv(int t);
        return (t == 0) || (t == 2) || (t == 13);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // advance n rising edges, then sample 1 ns later
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R2 field layout
    task automatic apply_routes();
        route_ab = {rt[0], rt[1]};
        route_cp = {rt[2], rt[5]};
        route_dp = {rt[3], rt[4]};
    endtask

    task automatic assert_src(int s, bit on);
        if (s < 4) pci_int_n[s] = ~on;
        else       pnp_req[s-4] = on;
    endtask

    task automatic chk_out(string req, logic [15:0] exp);
        check(irq_out == exp, req, {16'h0, irq_out}, {16'h0, exp});
    endtask

    initial begin
        tick(3);
        // R1: reset values
        chk_out("R1", 16'h0);
        check(bad_route == 6'h0, "R1", {26'h0, bad_route}, 32'h0);
        rst_n = 1'b1;
        tick(1);
        chk_out("R1", 16'h0);

        // R2 R3 R7 R9: each source to each target
        for (int s = 0; s < 6; s++) begin
            for (int t = 0; t < 16; t++) begin
                logic [15:0] e;
                logic [5:0]  b;
                for (int k = 0; k < 6; k++) rt[k] = 4'd0;
                rt[s] = 4'(t);
                apply_routes();
                assert_src(s, 1'b1);
                tick(4);
                e = is_rsv(t) ? 16'h0 : (16'h1 << t);
                b = 6'h3F & ~(6'h1 << s);
                if (is_rsv(t)) b = b | (6'h1 << s);
                chk_out(s < 4 ? "R2 R3 R7" : "R2 R9 R7", e);
                check(bad_route == b, "R7", {26'h0, bad_route}, {26'h0, b});
                assert_src(s, 1'b0);
                tick(4);
                chk_out("R3 R9 release", 16'h0);
            end
        end

        // distinct legal targets for the remaining tests
        rt[0] = 4'd3; rt[1] = 4'd4; rt[2] = 4'd5; rt[3] = 4'd6; rt[4] = 4'd7; rt[5] = 4'd8;
        apply_routes();
        tick(2);
        check(bad_route == 6'h0, "R7", {26'h0, bad_route}, 32'h0);

        // R3 latency: visible on the third edge, not the second
        pci_int_n[0] = 1'b0;
        tick(2);
        chk_out("R3 latency early", 16'h0);
        tick(1);
        chk_out("R3 latency", 16'h0008);
        // R9 latency
        pnp_req[1] = 1'b1;
        tick(2);
        chk_out("R9 latency early", 16'h0008);
        tick(1);
        chk_out("R9 latency", 16'h0108);
        // R8 all distinct at once
        pci_int_n = 4'h0; pnp_req = 2'b11;
        tick(4);
        chk_out("R8 all distinct", 16'h01F8);
        // R6: clear on level lines has no effect
        edge_clr = 4'hF;
        tick(1);
        edge_clr = 4'h0;
        tick(3);
        chk_out("R6 clear level", 16'h01F8);
        pci_int_n = 4'hF; pnp_req = 2'b00;
        tick(4);
        chk_out("R3 idle", 16'h0);

        // R4: upper mode bits ignored
        pol_cfg = 8'hF0;
        pci_int_n[1] = 1'b0;
        tick(4);
        chk_out("R4 upper bits", 16'h0010);
        pci_int_n[1] = 1'b1;
        pol_cfg = 8'h00;
        tick(4);

        // R4 R5 R6 R10 per edge line
        for (int i = 0; i < 4; i++) begin
            logic [15:0] e;
            e = 16'h1 << (3 + i);
            pol_cfg = 8'h1 << (3 - i);
            tick(4);
            chk_out("R4 edge idle", 16'h0);
            pci_int_n[i] = 1'b0;
            tick(4);
            chk_out("R4 R5 low no req", 16'h0);
            pci_int_n[i] = 1'b1;
            tick(3);
            chk_out("R5 latency early", 16'h0);
            tick(1);
            chk_out("R4 R5 set", e);
            pci_int_n[i] = 1'b0;
            tick(5);
            chk_out("R5 sticky", e);
            edge_clr[i] = 1'b1;
            tick(1);
            edge_clr[i] = 1'b0;
            tick(1);
            chk_out("R6 clear", 16'h0);
            // rising edge, then clear while pin held high
            pci_int_n[i] = 1'b1;
            tick(5);
            chk_out("R5 reset again", e);
            edge_clr[i] = 1'b1;
            tick(1);
            edge_clr[i] = 1'b0;
            tick(8);
            chk_out("R10 held high", 16'h0);
            // set wins over clear in the same cycle
            pci_int_n[i] = 1'b0;
            tick(4);
            pci_int_n[i] = 1'b1;
            tick(2);
            edge_clr[i] = 1'b1;
            tick(1);
            edge_clr[i] = 1'b0;
            tick(1);
            chk_out("R6 set wins", e);
            edge_clr[i] = 1'b1;
            tick(1);
            edge_clr[i] = 1'b0;
            tick(2);
            chk_out("R6 clear final", 16'h0);
            pol_cfg = 8'h00;
            tick(3);
        end

        // R8: sharing one target
        rt[0] = 4'd9; rt[1] = 4'd9; rt[4] = 4'd9;
        apply_routes();
        pci_int_n[0] = 1'b0;
        tick(4);
        chk_out("R8 A only", 16'h0200);
        pci_int_n[0] = 1'b1; pci_int_n[1] = 1'b0;
        tick(4);
        chk_out("R8 B only", 16'h0200);
        pci_int_n[0] = 1'b0; pnp_req[0] = 1'b1;
        tick(4);
        chk_out("R8 three shared", 16'h0200);
        pci_int_n = 4'hF; pnp_req = 2'b00;
        tick(4);
        chk_out("R8 none", 16'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule